// File: doc/BRIEF.md
# GPIO Interrupt Trigger and Status Unit

This block watches a bank of already synchronized GPIO pin inputs and raises one interrupt request when a pin shows its configured event. A two-bit code per pin selects the event. The code is formed from a trigger-select bit and an invert bit, and picks rising edge, falling edge, active-low level or active-high level. Each detected event sets a sticky status bit. The status bits are masked by per-pin enable bits, and every enabled pending bit is ORed into a single registered interrupt output.

Software reaches the unit through a simple word-wide register port with 32 bits per word. Status words are read directly and cleared by writing ones. Enable words are read and written whole. Service code clears a status bit before handling the event, so an edge that arrives during service marks the bit again. Pins that are not in GPIO mode, or whose input sensing is off, never raise status.

Top module: `gpio_irq_unit`

## Requirements
- R1: Trigger code {trig_lvl,trig_inv} = 00 sets the pin's status bit on a rising edge only. A held high level or a falling edge does not set it again.
- R2: Code 01 sets the status bit on a falling edge only.
- R3: Code 10 sets the status bit in every cycle the pin is low, so a clear has no lasting effect while the pin stays low.
- R4: Code 11 sets the status bit in every cycle the pin is high, and never while it is low.
- R5: A write with bus_addr[1]=0 targets status word bus_addr[0]. Each 1 in bus_wdata clears the matching bit (pin = word*32 + bit), and each 0 leaves its bit unchanged.
- R6: When a detection and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R7: A write with bus_addr[1]=1 loads enable word bus_addr[0] with bus_wdata. Enable words are all zero after reset.
- R8: irq_out is registered. It is high in the cycle after any bit is set in both status and enable, and it is low otherwise.
- R9: A pin with pin_gpio_mode=0 or pin_sense_en=0 never sets its status bit.
- R10: bus_rdata returns the word selected by bus_addr one clock later. Bits that map to pin numbers at or above NUM_PINS read as 0.
- R11: Once a status bit has been cleared, a later qualifying edge on that pin sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| pin_trig_lvl | input | NUM_PINS | Per-pin trigger select: 0 edge, 1 level |
| pin_trig_inv | input | NUM_PINS | Per-pin invert bit |
| pin_gpio_mode | input | NUM_PINS | 1 when the pin is used as GPIO |
| pin_sense_en | input | NUM_PINS | 1 when input sensing is on |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Bank select (top bit) and word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Detection and a write-one-to-clear can land on the same status bit at the same clock edge. The bench provokes this by raising a rising-edge pin at the same falling clock edge where it drives a clearing write to that bit. It then reads the status word and expects the bit still set. A follow-up ordinary clear must remove the bit, and a fresh edge after the clear must set it once more.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    TRG_RISE = 2'b00,
    TRG_FALL = 2'b01,
    TRG_LOW  = 2'b10,
    TRG_HIGH = 2'b11
  } trig_code_e;

  function automatic int unsigned word_count(input int unsigned pins);
    return (pins + BUS_W - 1) / BUS_W;
  endfunction
endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] trig_lvl,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic [NUM_PINS-1:0] gpio_mode,
  input  logic [NUM_PINS-1:0] sense_en,
  output logic [NUM_PINS-1:0] hit
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_in;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    trig_code_e code;
    logic       event_seen;
    assign code = trig_code_e'({trig_lvl[i], trig_inv[i]});
    always_comb begin
      unique case (code)
        TRG_RISE: event_seen = pin_in[i] & ~prev_q[i];
        TRG_FALL: event_seen = ~pin_in[i] & prev_q[i];
        TRG_LOW:  event_seen = ~pin_in[i];
        TRG_HIGH: event_seen = pin_in[i];
        default:  event_seen = 1'b0;
      endcase
    end
    assign hit[i] = event_seen & gpio_mode[i] & sense_en[i];

    AST_HIGH_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
      (code == TRG_HIGH && !pin_in[i]) |-> !hit[i]); // R4
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned NUM_WORDS = word_count(NUM_PINS),
  parameter int unsigned WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] hit,
  input  logic                wr_en,
  input  logic [WIDX_W-1:0]   word_idx,
  input  logic [BUS_W-1:0]    wdata,
  output logic [NUM_PINS-1:0] status_q
);
  logic [NUM_PINS-1:0] clr_mask;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_clr
    localparam int unsigned W = i / BUS_W;
    localparam int unsigned B = i % BUS_W;
    assign clr_mask[i] = wr_en && (word_idx == WIDX_W'(W)) && wdata[B];
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_mask) | hit;
  end

  AST_DETECT_WINS: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit))); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0) |=> ((status_q & $past(clr_mask & ~hit)) == '0)); // R5
  AST_SET_ONLY_BY_HIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0)); // R9
endmodule

// File: rtl/gpio_irq_enable.sv
module gpio_irq_enable
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned NUM_WORDS = word_count(NUM_PINS),
  parameter int unsigned WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WIDX_W-1:0]   word_idx,
  input  logic [BUS_W-1:0]    wdata,
  output logic [NUM_PINS-1:0] enable_q
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    localparam int unsigned W = i / BUS_W;
    localparam int unsigned B = i % BUS_W;
    always_ff @(posedge clk) begin
      if (rst) enable_q[i] <= 1'b0;
      else if (wr_en && word_idx == WIDX_W'(W)) enable_q[i] <= wdata[B];
    end

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && word_idx == WIDX_W'(W)) |=> enable_q[i] == $past(wdata[B])); // R7
  end

  AST_EN_RESET: assert property (@(posedge clk)
    rst |=> enable_q == '0); // R7
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned NUM_WORDS = word_count(NUM_PINS),
  parameter int unsigned WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  parameter int unsigned ADDR_W = WIDX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] pin_trig_lvl,
  input  logic [NUM_PINS-1:0] pin_trig_inv,
  input  logic [NUM_PINS-1:0] pin_gpio_mode,
  input  logic [NUM_PINS-1:0] pin_sense_en,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic                irq_out
);
  logic                bank_en;
  logic [WIDX_W-1:0]   word_idx;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] enable_q;
  logic [NUM_PINS-1:0] qual;
  logic                any_pending;
  logic [BUS_W-1:0]    stat_words [NUM_WORDS];
  logic [BUS_W-1:0]    en_words   [NUM_WORDS];

  assign bank_en  = bus_addr[ADDR_W-1];
  assign word_idx = bus_addr[WIDX_W-1:0];
  assign qual     = pin_gpio_mode & pin_sense_en;

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .trig_lvl(pin_trig_lvl), .trig_inv(pin_trig_inv),
    .gpio_mode(pin_gpio_mode), .sense_en(pin_sense_en), .hit(hit)
  );

  gpio_irq_status #(.NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W)) u_status (
    .clk(clk), .rst(rst), .hit(hit), .wr_en(bus_wr && !bank_en),
    .word_idx(word_idx), .wdata(bus_wdata), .status_q(status_q)
  );

  gpio_irq_enable #(.NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W)) u_enable (
    .clk(clk), .rst(rst), .wr_en(bus_wr && bank_en),
    .word_idx(word_idx), .wdata(bus_wdata), .enable_q(enable_q)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BUS_W; b++) begin : g_bit
      localparam int unsigned IDX = w * BUS_W + b;
      if (IDX < NUM_PINS) begin : g_live
        assign stat_words[w][b] = status_q[IDX];
        assign en_words[w][b]   = enable_q[IDX];
      end else begin : g_pad
        assign stat_words[w][b] = 1'b0;
        assign en_words[w][b]   = 1'b0;
      end
    end
  end

  assign any_pending = |(status_q & enable_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_out <= any_pending;
      if (32'(word_idx) < NUM_WORDS)
        bus_rdata <= bank_en ? en_words[word_idx] : stat_words[word_idx];
      else
        bus_rdata <= '0;
    end
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_out == $past(|(status_q & enable_q))); // R8
  AST_UNQUALIFIED_QUIET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(qual)) == '0)); // R9
endmodule

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/100ps
module gpio_irq_unit_bench;
  localparam int NP = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] trig_lvl = '0;
  logic [NP-1:0] trig_inv = '0;
  logic [NP-1:0] gpio_mode = '1;
  logic [NP-1:0] sense_en = '1;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_trig_lvl(trig_lvl),
    .pin_trig_inv(trig_inv), .pin_gpio_mode(gpio_mode), .pin_sense_en(sense_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    pin_in[i] = v;
  endtask

  task automatic clear_all();
    wr(2'b00, 32'hFFFF_FFFF);
    wr(2'b01, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R8 reset irq", {31'b0, irq_out}, 32'h0);
    rd(2'b00, d); check("R10 reset status w0", d, 32'h0);
    rd(2'b01, d); check("R10 reset status w1", d, 32'h0);
    rd(2'b10, d); check("R7 reset enable w0", d, 32'h0);
    rd(2'b11, d); check("R7 reset enable w1", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_pin(3, 1'b1);
    rd(2'b00, d); check("R1 rising sets", d, 32'h8);
    wr(2'b00, 32'h8);
    rd(2'b00, d); check("R1 held high no reset", d, 32'h0);
    set_pin(3, 1'b0);
    rd(2'b00, d); check("R1 falling ignored", d, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    trig_inv[5] = 1'b1;
    set_pin(5, 1'b1);
    rd(2'b00, d); check("R2 rising ignored", d, 32'h0);
    set_pin(5, 1'b0);
    rd(2'b00, d); check("R2 falling sets", d, 32'h20);
    clear_all();
    trig_inv[5] = 1'b0;
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    @(negedge clk); trig_lvl[34] = 1'b1; trig_inv[34] = 1'b0;
    rd(2'b01, d); check("R3 low level sets", d, 32'h4);
    wr(2'b01, 32'h4);
    rd(2'b01, d); check("R3 clear no lasting effect", d, 32'h4);
    set_pin(34, 1'b1);
    wr(2'b01, 32'h4);
    rd(2'b01, d); check("R3 cleared after release", d, 32'h0);
    @(negedge clk); trig_lvl[34] = 1'b0;
    set_pin(34, 1'b0);
    clear_all();
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    @(negedge clk); trig_lvl[35] = 1'b1; trig_inv[35] = 1'b1;
    rd(2'b01, d); check("R4 low pin no set", d, 32'h0);
    set_pin(35, 1'b1);
    rd(2'b01, d); check("R4 high level sets", d, 32'h8);
    set_pin(35, 1'b0);
    wr(2'b01, 32'h8);
    rd(2'b01, d); check("R4 cleared when low", d, 32'h0);
    @(negedge clk); trig_lvl[35] = 1'b0; trig_inv[35] = 1'b0;
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    @(negedge clk); pin_in[1] = 1'b1; pin_in[2] = 1'b1; pin_in[33] = 1'b1;
    rd(2'b00, d); check("R5 two set", d, 32'h6);
    wr(2'b00, 32'h2);
    rd(2'b00, d); check("R5 zero bits kept", d, 32'h4);
    rd(2'b01, d); check("R5 other word untouched", d, 32'h2);
    clear_all();
    @(negedge clk); pin_in[1] = 1'b0; pin_in[2] = 1'b0; pin_in[33] = 1'b0;
  endtask

  task automatic t_collide();
    logic [31:0] d;
    set_pin(7, 1'b1);
    set_pin(7, 1'b0);
    @(negedge clk);
    pin_in[7] = 1'b1; bus_wr = 1'b1; bus_addr = 2'b00; bus_wdata = 32'h80;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(2'b00, d); check("R6 detect beats clear", d, 32'h80);
    wr(2'b00, 32'h80);
    rd(2'b00, d); check("R6 plain clear", d, 32'h0);
    set_pin(7, 1'b0);
    set_pin(7, 1'b1);
    rd(2'b00, d); check("R11 edge after clear", d, 32'h80);
    clear_all();
    set_pin(7, 1'b0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    set_pin(10, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 pending not enabled", {31'b0, irq_out}, 32'h0);
    wr(2'b10, 32'h200);
    rd(2'b10, d); check("R7 enable readback", d, 32'h200);
    @(negedge clk); pin_in[9] = 1'b1;
    @(negedge clk); check("R8 irq one cycle late", {31'b0, irq_out}, 32'h0);
    @(negedge clk); check("R8 irq raised", {31'b0, irq_out}, 32'h1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'b00; bus_wdata = 32'h200;
    @(negedge clk); bus_wr = 1'b0;
    check("R8 irq still registered", {31'b0, irq_out}, 32'h1);
    @(negedge clk); check("R8 irq dropped", {31'b0, irq_out}, 32'h0);
    wr(2'b10, 32'h0);
    clear_all();
    @(negedge clk); pin_in[9] = 1'b0; pin_in[10] = 1'b0;
  endtask

  task automatic t_qualify();
    logic [31:0] d;
    @(negedge clk); gpio_mode[11] = 1'b0; sense_en[12] = 1'b0;
    trig_lvl[13] = 1'b1; trig_inv[13] = 1'b1; sense_en[13] = 1'b0;
    @(negedge clk); pin_in[11] = 1'b1; pin_in[12] = 1'b1; pin_in[13] = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'b00, d); check("R9 unqualified pins quiet", d, 32'h0);
    @(negedge clk); pin_in[11] = 1'b0; pin_in[12] = 1'b0; pin_in[13] = 1'b0;
    gpio_mode[11] = 1'b1; sense_en[12] = 1'b1; sense_en[13] = 1'b1;
    trig_lvl[13] = 1'b0; trig_inv[13] = 1'b0;
  endtask

  task automatic t_pad();
    logic [31:0] d;
    wr(2'b11, 32'hFFFF_FFFF);
    rd(2'b11, d); check("R10 pad bits read zero", d, 32'h0000_00FF);
    wr(2'b11, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rise();
    t_fall();
    t_level_low();
    t_level_high();
    t_w1c();
    t_collide();
    t_irq();
    t_qualify();
    t_pad();
    finish_run();
  end
endmodule